// File: doc/BRIEF.md
# Configurable Match Indicator Outputs

This block turns four internal one-cycle event pulses (destination-address match, source-address match, source-route match and abort) into four pin-level indicator signals, all registered on the data clock. Each indicator has its own programmed active level. Each also has its own deassertion mode: either a single-clock pulse, or a level that is held until a control symbol arrives in the receive stream.

The configuration arrives as a 16-bit word. Only its low byte affects this block. Bits 7 to 4 hold the polarities and bits 3 to 0 hold the length modes. The upper byte carries filtering-polarity, discard and learn-enable controls that other logic uses, and this block ignores it. A single input tells the block that a control symbol was received in the current cycle.

Top module: `match_indicator_out`

## Requirements
- R1: Config bits 7, 6, 5 and 4 set the active level of the destination-match, source-match, source-route-match and abort pins respectively (event vector bits 3, 2, 1, 0 in the same order). A 1 means active high and a 0 means active low. An event sampled at a clock edge drives its pin to the active level right after that edge.
- R2: When a channel's length bit (bits 3, 2, 1, 0 in the same channel order) is 0, its pin returns to the inactive level at the next edge unless another event is sampled there. A control symbol has no effect in this mode.
- R3: When a channel's length bit is 1, an asserted pin stays active until the edge at which a control symbol is sampled. It is inactive right after that edge.
- R4: In held mode, a new event on a pin that is already active keeps it active, with no inactive cycle.
- R5: In held mode, if an event and a control symbol are sampled at the same edge, the pin stays active.
- R6: While rst_n is low (synchronous, active low), every pin is driven to its inactive level under the polarity present at each edge, and events are ignored.
- R7: A change of a polarity bit appears on the pin at the next clock edge, and the channel's asserted or idle state is kept.
- R8: Config bits 15 to 8 have no effect on any pin.
- R9: Each channel is independent: an event on one channel moves only that channel's pin.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Data clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_word | input | 16 | Configuration word; [7:4] polarity, [3:0] length mode |
| evt_i | input | 4 | One-cycle events: [3] dest, [2] source, [1] route, [0] abort |
| ctrl_sym_i | input | 1 | A control symbol was received this cycle |
| dst_match_o | output | 1 | Destination-address match indicator |
| src_match_o | output | 1 | Source-address match indicator |
| route_match_o | output | 1 | Source-route match indicator |
| abort_o | output | 1 | Abort indicator |

## Verification
The assertions assume that cfg_word, evt_i and ctrl_sym_i are driven to known values from the first clock edge onward, because their checks compare each pin with the polarity bit sampled one edge earlier. They also assume that events are single-cycle strobes, and they place no rule on how events and control symbols may coincide. The stimulus changes inputs only on the falling edge, drives cfg_word from time zero, and draws events and control symbols from a pseudo-random sequence in which both are sparse but do sometimes coincide. This covers every low-byte configuration, with the upper byte scrambled.

// File: rtl/match_indicator_out.sv
module match_indicator_out #(
  parameter int NCH = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [15:0] cfg_word,
  input  logic [3:0]  evt_i,
  input  logic        ctrl_sym_i,
  output logic        dst_match_o,
  output logic        src_match_o,
  output logic        route_match_o,
  output logic        abort_o
);

  logic [NCH-1:0] pol, len, act_q, act_d, pin_q;

  assign pol = cfg_word[2*NCH-1:NCH];
  assign len = cfg_word[NCH-1:0];

  // held channels clear on a control symbol; a new event always wins
  assign act_d = evt_i | (len & act_q & ~{NCH{ctrl_sym_i}});

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act_q <= '0;
      pin_q <= ~pol;
    end else begin
      act_q <= act_d;
      pin_q <= ~(act_d ^ pol);
    end
  end

  assign dst_match_o   = pin_q[3];
  assign src_match_o   = pin_q[2];
  assign route_match_o = pin_q[1];
  assign abort_o       = pin_q[0];

  for (genvar g = 0; g < NCH; g++) begin : g_chk
    // R6
    reset_idle_chk: assert property (@(posedge clk)
      !rst_n |=> pin_q[g] == ~$past(pol[g]));
    // R1
    event_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
      evt_i[g] |=> pin_q[g] == $past(pol[g]));
    // R2
    pulse_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!len[g] && !evt_i[g]) |=> pin_q[g] == ~$past(pol[g]));
    // R3
    held_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (len[g] && act_q[g] && !ctrl_sym_i) |=> pin_q[g] == $past(pol[g]));
    // R3
    held_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (len[g] && ctrl_sym_i && !evt_i[g]) |=> pin_q[g] == ~$past(pol[g]));
    // R4
    retrigger_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (len[g] && act_q[g] && evt_i[g]) |=> pin_q[g] == $past(pol[g]));
    // R5
    coincide_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (len[g] && ctrl_sym_i && evt_i[g]) |=> pin_q[g] == $past(pol[g]));
  end

endmodule

// File: tb/match_indicator_out_test.sv
module match_indicator_out_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [15:0] cfg = 16'h0000;
  logic [3:0] evt = 4'h0;
  logic ctrl = 1'b0;
  logic dst, src, route, abt;

  match_indicator_out uut (
    .clk(clk), .rst_n(rst_n), .cfg_word(cfg), .evt_i(evt), .ctrl_sym_i(ctrl),
    .dst_match_o(dst), .src_match_o(src), .route_match_o(route), .abort_o(abt)
  );

  always #10 clk = ~clk;

  int tests = 0, fails = 0;
  logic [3:0] m_act = 4'h0;
  logic [15:0] lfsr = 16'hACE1;
  string force_tag = "";
  bit done = 0;

  task automatic adv();
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
  endtask

  task automatic step(input logic [15:0] c, input logic [3:0] e, input logic k, input logic r);
    logic [3:0] got, pol, len, m_pin;
    string tag[4];
    cfg = c; evt = e; ctrl = k; rst_n = r;
    pol = c[7:4]; len = c[3:0];
    for (int i = 0; i < 4; i++) begin
      if (force_tag != "") tag[i] = force_tag;
      else if (!r) tag[i] = "R6";
      else if (len[i] && e[i] && k) tag[i] = "R5";
      else if (len[i] && e[i] && m_act[i]) tag[i] = "R4";
      else if (len[i]) tag[i] = "R3";
      else if (e[i]) tag[i] = "R1";
      else tag[i] = "R2";
    end
    if (!r) m_act = 4'h0;
    else m_act = e | (len & m_act & {4{~k}});
    for (int i = 0; i < 4; i++) m_pin[i] = pol[i] ? m_act[i] : ~m_act[i];
    @(posedge clk);
    @(negedge clk);
    got = {dst, src, route, abt};
    for (int i = 0; i < 4; i++) begin
      tests++;
      if (got[i] !== m_pin[i]) begin
        fails++;
        $display("FAIL %s ch%0d cfg=%h got %b expected %b", tag[i], i, c, got[i], m_pin[i]);
      end
    end
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    // R6: reset drives inactive level for every polarity, events ignored
    for (int p = 0; p < 16; p++) begin
      adv();
      step({8'h00, p[3:0], 4'hF}, lfsr[3:0], lfsr[4], 1'b0);
    end
    // sweep every low-byte configuration
    for (int c = 0; c < 256; c++) begin
      for (int n = 0; n < 24; n++) begin
        adv();
        step({lfsr[15:8], c[7:0]}, lfsr[3:0] & lfsr[7:4], lfsr[8] & lfsr[9], 1'b1);
      end
    end
    // R7: polarity change shows at next edge, state kept
    force_tag = "R7";
    step(16'h00FF, 4'hF, 1'b0, 1'b1);
    step(16'h000F, 4'h0, 1'b0, 1'b1);
    step(16'h00FF, 4'h0, 1'b0, 1'b1);
    step(16'h00F0, 4'h0, 1'b1, 1'b1);
    step(16'h0000, 4'h0, 1'b0, 1'b1);
    step(16'h00A0, 4'h0, 1'b0, 1'b1);
    // R8: upper byte has no effect
    force_tag = "R8";
    step(16'h00AF, 4'hF, 1'b0, 1'b1);
    for (int u = 0; u < 256; u++) begin
      adv();
      step({u[7:0], 8'hA5}, (u < 128) ? 4'h0 : (lfsr[3:0] & lfsr[7:4]), (u < 128) ? 1'b0 : lfsr[8], 1'b1);
    end
    // R9: channels independent
    force_tag = "R9";
    for (int i = 0; i < 4; i++) begin
      step(16'h00F0, 4'(1 << i), 1'b0, 1'b1);
      step(16'h00F0, 4'h0, 1'b0, 1'b1);
    end
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule